// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding and Drain Barriers

This block sits between a core's in-order request stream and one single-ported memory port. Stores are parked in a small circular queue and written out one at a time, oldest first, whenever the memory port is free. A load searches the queue first. If one or more parked stores carry its address, the youngest of them supplies the data at once. Otherwise the load reads memory directly, and it may do so ahead of older stores that are still parked for other addresses.

Two commands remove that freedom. A barrier command holds back every younger request until the queue is empty, then raises a one-cycle done pulse. A locked fetch-and-add first empties the queue, then reads memory, writes back the old value plus the operand straight to memory, and only then returns the old value. The queue is never consulted for the locked access.

Only one load or locked operation is in flight at a time. All accesses are full words at word-aligned addresses.

Top module: `sbuf_top`

## Requirements
- R1: A store (req_op = 1) is written to memory exactly once, with its own address and data. Memory writes leave in program order, including the write of a locked operation.
- R2: A load (req_op = 0) returns the data of the most recent earlier store to its address. When the queue holds a matching entry, the youngest such entry supplies the data and rsp_valid is high in the cycle after the load is accepted.
- R3: A load whose address is in no queue entry is sent to memory as a read, even while older stores to other addresses are still queued.
- R4: A barrier (req_op = 2) keeps req_ready low until the queue is empty. fence_done pulses in the cycle after the last queued write is accepted, or in the cycle after the barrier is accepted when the queue is already empty at that point.
- R5: A locked add (req_op = 3) issues its memory read only after every older store has been written. It writes old value plus req_wdata to memory before rsp_valid returns the old value.
- R6: With DEPTH entries queued, req_ready is low for a store. Loads, barriers and locked adds are still accepted when the block is idle.
- R7: A queue entry is released only in a cycle where the memory accepts its write (mem_valid, mem_we and mem_ready all high).
- R8: After reset, req_ready is high and mem_valid, rsp_valid and fence_done are low.
- R9: While a load or locked add is waiting for its response, req_ready stays low. rsp_valid marks the end of that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 0 load, 1 store, 2 barrier, 3 locked add |
| req_addr | input | AW | Word-aligned address |
| req_wdata | input | DW | Store data or add operand |
| rsp_valid | output | 1 | One-cycle pulse carrying load or locked-add result |
| rsp_data | output | DW | Result data |
| fence_done | output | 1 | One-cycle pulse when a barrier completes |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | DW | Read data |

## Verification
The bench builds the block with DEPTH = 4 and 32-bit addresses and data, and spreads its traffic over six word addresses. The small depth makes a full queue and pointer wraparound common under a memory that refuses about one request in four. The narrow address range means loads often find two or more matching entries, so youngest-entry selection gets exercised. A directed phase holds off memory writes alone, which keeps stores queued while a missing load reads memory and while the queue fills.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_STORE   = 2'd1,
        OP_FENCE   = 2'd2,
        OP_LOCKADD = 2'd3
    } sb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_RD,
        ST_LD_WAIT,
        ST_FN_DRAIN,
        ST_LK_DRAIN,
        ST_LK_RD,
        ST_LK_WAIT,
        ST_LK_WR
    } sb_state_e;

endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] look_addr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    typedef struct packed {
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
    } q_t;

    q_t r_q, r_d;
    logic [DEPTH-1:0] addr_eq;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // per-entry address comparators
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign addr_eq[g] = (r_q.addr[g] == look_addr);
    end

    // youngest live match wins: scan from oldest to youngest, last hit stays
    always_comb begin
        logic [PW:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = {1'b0, r_q.head} + (PW+1)'(k);
            if (idx >= (PW+1)'(DEPTH)) idx = idx - (PW+1)'(DEPTH);
            if ((CW'(k) < r_q.count) && addr_eq[idx[PW-1:0]]) begin
                hit      = 1'b1;
                hit_data = r_q.data[idx[PW-1:0]];
            end
        end
    end

    always_comb begin
        r_d = r_q;
        if (pop) begin
            r_d.head = wrap_inc(r_q.head);
        end
        if (push) begin
            r_d.addr[r_q.tail] = push_addr;
            r_d.data[r_q.tail] = push_data;
            r_d.tail           = wrap_inc(r_q.tail);
        end
        r_d.count = r_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count     = r_q.count;
    assign empty     = (r_q.count == '0);
    assign full      = (r_q.count == CW'(DEPTH));
    assign head_addr = r_q.addr[r_q.head];
    assign head_data = r_q.data[r_q.head];

    // R6: the controller never pushes into a full queue
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (r_q.count < CW'(DEPTH)));

    // R1: retirement only ever removes a live entry
    p_pop_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (r_q.count != '0));

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic [CW-1:0] q_count,
    input  logic          q_empty,
    input  logic          q_full,
    input  logic          q_hit,
    input  logic [DW-1:0] q_hit_data,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    output logic          push,
    output logic          pop,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          fence_done
);

    typedef struct packed {
        sb_state_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] opnd;
        logic [DW-1:0] old;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
        logic          fence_done;
    } ctrl_t;

    ctrl_t r_q, r_d;
    sb_op_e op;
    logic   retire_slot;
    logic   last_out;

    always_comb begin
        r_d            = r_q;
        r_d.rsp_valid  = 1'b0;
        r_d.fence_done = 1'b0;
        op             = sb_op_e'(req_op);
        req_ready      = 1'b0;
        push           = 1'b0;
        pop            = 1'b0;
        mem_valid      = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = head_addr;
        mem_wdata      = head_data;

        // the port drains the queue whenever no read or locked write owns it
        retire_slot = !(r_q.st inside {ST_LD_RD, ST_LK_RD, ST_LK_WR});
        if (retire_slot && !q_empty) begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            pop       = mem_ready;
        end
        last_out = pop && (q_count == CW'(1));

        unique case (r_q.st)
            ST_IDLE: begin
                req_ready = (op == OP_STORE) ? !q_full : 1'b1;
                if (req_valid && req_ready) begin
                    unique case (op)
                        OP_STORE: push = 1'b1;
                        OP_LOAD: begin
                            if (q_hit) begin
                                r_d.rsp_valid = 1'b1;
                                r_d.rsp_data  = q_hit_data;
                            end else begin
                                r_d.addr = req_addr;
                                r_d.st   = ST_LD_RD;
                            end
                        end
                        OP_FENCE: begin
                            if (q_empty || last_out) r_d.fence_done = 1'b1;
                            else                     r_d.st         = ST_FN_DRAIN;
                        end
                        OP_LOCKADD: begin
                            r_d.addr = req_addr;
                            r_d.opnd = req_wdata;
                            r_d.st   = (q_empty || last_out) ? ST_LK_RD : ST_LK_DRAIN;
                        end
                        default: ;
                    endcase
                end
            end
            ST_LD_RD: begin
                mem_valid = 1'b1;
                mem_addr  = r_q.addr;
                if (mem_ready) r_d.st = ST_LD_WAIT;
            end
            ST_LD_WAIT: begin
                if (mem_rvalid) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = mem_rdata;
                    r_d.st        = ST_IDLE;
                end
            end
            ST_FN_DRAIN: begin
                if (last_out) begin
                    r_d.fence_done = 1'b1;
                    r_d.st         = ST_IDLE;
                end
            end
            ST_LK_DRAIN: begin
                if (last_out) r_d.st = ST_LK_RD;
            end
            ST_LK_RD: begin
                mem_valid = 1'b1;
                mem_addr  = r_q.addr;
                if (mem_ready) r_d.st = ST_LK_WAIT;
            end
            ST_LK_WAIT: begin
                if (mem_rvalid) begin
                    r_d.old = mem_rdata;
                    r_d.st  = ST_LK_WR;
                end
            end
            ST_LK_WR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.addr;
                mem_wdata = r_q.old + r_q.opnd;
                if (mem_ready) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = r_q.old;
                    r_d.st        = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_data   = r_q.rsp_data;
    assign fence_done = r_q.fence_done;

    // R4: nothing younger enters while a barrier drains
    p_fence_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FN_DRAIN) |-> !req_ready);

    // R4: a barrier only completes on an empty queue
    p_fence_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> q_empty);

    // R5: the locked read and write see an empty queue
    p_lock_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_LK_RD || r_q.st == ST_LK_WR) && mem_valid) |-> q_empty);

    // R9: a second load or locked add waits for the first to answer
    p_one_inflight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st inside {ST_LD_RD, ST_LD_WAIT, ST_LK_RD, ST_LK_WAIT, ST_LK_WR})
            |-> !req_ready);

endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          fence_done,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop;
    logic [CW-1:0] q_count;
    logic          q_empty, q_full, q_hit;
    logic [DW-1:0] q_hit_data, head_data;
    logic [AW-1:0] head_addr;

    sbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (pop),
        .look_addr (req_addr),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full),
        .head_addr (head_addr),
        .head_data (head_data),
        .hit       (q_hit),
        .hit_data  (q_hit_data)
    );

    sbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .q_count    (q_count),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .q_hit      (q_hit),
        .q_hit_data (q_hit_data),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .push       (push),
        .pop        (pop),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .fence_done (fence_done)
    );

    // R7: occupancy never drops in a cycle the memory refused
    p_free_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |=> (q_count >= $past(q_count)));

endmodule

// File: tb/sbuf_top_bench.sv
module sbuf_top_bench;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          fence_done;
    logic          mem_valid;
    logic          mem_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    logic rdy_rand = 1'b1;
    logic wr_block = 1'b0;
    bit   rand_ready = 1'b0;

    assign mem_ready = rdy_rand && !(wr_block && mem_we);

    always #5 clk = ~clk;

    sbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sbuf_top (.*);

    // behavioural reference state
    logic [DW-1:0] bmem [16];
    logic [DW-1:0] prog [16];
    logic [AW-1:0] ewa [$];
    logic [DW-1:0] ewd [$];
    logic [DW-1:0] erd [$];
    bit   blk, lock_wait, fence_wait, fdone_due, hit_due, rd_pend, acc;
    logic [DW-1:0] rd_data;
    int   checks, failures, cyc, bypass_cnt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        bit pre_hit;
        bit fnext;
        @(negedge clk);
        mem_rvalid = rd_pend;
        mem_rdata  = rd_data;
        rd_pend    = 1'b0;
        rdy_rand   = rand_ready ? ($urandom_range(3) != 0) : 1'b1;
        #1;
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        fnext = 1'b0;
        chk(fence_done == fdone_due, "R4 fence_done timing", 32'(fence_done), 32'(fdone_due));
        if (fence_done) fence_wait = 1'b0;
        if (hit_due) chk(rsp_valid, "R2 forwarded load latency", 32'(rsp_valid), 32'd1);
        hit_due = 1'b0;
        if (rsp_valid) begin
            if (erd.size() == 0) chk(1'b0, "R2 R5 unexpected response", rsp_data, 32'd0);
            else begin
                chk(rsp_data == erd[0], "R2 R5 response data", rsp_data, erd[0]);
                void'(erd.pop_front());
            end
            if (lock_wait) begin
                chk(ewa.size() == 0, "R5 locked write before completion", 32'(ewa.size()), 32'd0);
                lock_wait = 1'b0;
            end
            blk = 1'b0;
        end
        if (blk || fence_wait)
            chk(!req_ready, "R9 R4 younger request held", 32'(req_ready), 32'd0);
        else if (req_valid)
            chk(req_ready == !(req_op == 2'd1 && ewa.size() >= DEPTH), "R6 ready versus occupancy",
                32'(req_ready), 32'(!(req_op == 2'd1 && ewa.size() >= DEPTH)));
        pre_hit = 1'b0;
        foreach (ewa[i]) if (ewa[i] == req_addr) pre_hit = 1'b1;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                if (ewa.size() == 0) chk(1'b0, "R1 unexpected write", mem_addr, 32'd0);
                else begin
                    chk(mem_addr == ewa[0], "R1 retire address order", mem_addr, ewa[0]);
                    chk(mem_wdata == ewd[0], "R1 retire data order", mem_wdata, ewd[0]);
                    bmem[mem_addr[5:2]] = mem_wdata;
                    void'(ewa.pop_front());
                    void'(ewd.pop_front());
                end
                if (ewa.size() == 0 && fence_wait) fnext = 1'b1;
            end else begin
                rd_pend = 1'b1;
                rd_data = bmem[mem_addr[5:2]];
                if (lock_wait)
                    chk(ewa.size() == 1, "R5 queue drained before locked read", 32'(ewa.size()), 32'd1);
                else if (ewa.size() > 0)
                    bypass_cnt++;
            end
        end
        if (req_valid && req_ready) begin
            acc = 1'b1;
            case (req_op)
                2'd1: begin
                    ewa.push_back(req_addr);
                    ewd.push_back(req_wdata);
                    prog[req_addr[5:2]] = req_wdata;
                end
                2'd0: begin
                    erd.push_back(prog[req_addr[5:2]]);
                    blk = 1'b1;
                    if (pre_hit) hit_due = 1'b1;
                end
                2'd2: begin
                    if (ewa.size() == 0) fnext = 1'b1;
                    else                 fence_wait = 1'b1;
                end
                default: begin
                    erd.push_back(prog[req_addr[5:2]]);
                    ewa.push_back(req_addr);
                    ewd.push_back(prog[req_addr[5:2]] + req_wdata);
                    prog[req_addr[5:2]] = prog[req_addr[5:2]] + req_wdata;
                    blk = 1'b1;
                    lock_wait = 1'b1;
                end
            endcase
        end
        fdone_due = fnext;
        @(posedge clk);
        #1;
    endtask

    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = d;
        acc       = 1'b0;
        while (!acc) tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (blk || fence_wait || fdone_due || ewa.size() != 0) tick();
        tick();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            bmem[i] = 32'h100 + 32'(i);
            prog[i] = 32'h100 + 32'(i);
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(req_ready == 1'b1, "R8 reset req_ready", 32'(req_ready), 32'd1);
        chk(mem_valid == 1'b0, "R8 reset mem_valid", 32'(mem_valid), 32'd0);
        chk(rsp_valid == 1'b0, "R8 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(fence_done == 1'b0, "R8 reset fence_done", 32'(fence_done), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R2 / R3: stores held back, youngest forwarding and miss bypass
        wr_block = 1'b1;
        do_req(2'd1, 32'h4, 32'h11);
        do_req(2'd1, 32'h8, 32'h22);
        do_req(2'd1, 32'h4, 32'h33);
        do_req(2'd0, 32'h4, 32'h0);
        wait_rsp();
        do_req(2'd0, 32'hC, 32'h0);
        wait_rsp();
        chk(bypass_cnt > 0, "R3 miss read ahead of queued stores", 32'(bypass_cnt), 32'd1);

        // R6 / R7: fill queue while writes are refused
        while (ewa.size() < DEPTH) do_req(2'd1, 32'h10, 32'h40 + 32'(ewa.size()));
        req_valid = 1'b1; req_op = 2'd1; req_addr = 32'h14; req_wdata = 32'h99; acc = 1'b0;
        repeat (5) tick();
        chk(acc == 1'b0, "R6 store stalled when full", 32'(acc), 32'd0);
        chk(ewa.size() == DEPTH, "R7 no entry freed while refused", 32'(ewa.size()), 32'(DEPTH));
        req_valid = 1'b0;
        do_req(2'd0, 32'h10, 32'h0);
        wait_rsp();

        // R4: barrier drains, then memory holds the youngest value
        wr_block = 1'b0;
        do_req(2'd2, 32'h0, 32'h0);
        wait_idle();
        chk(bmem[1] == 32'h33, "R1 memory after drain", bmem[1], 32'h33);
        do_req(2'd2, 32'h0, 32'h0);
        wait_idle();

        // R5: locked add behind a queued store to the same word
        wr_block = 1'b1;
        do_req(2'd1, 32'h18, 32'h5);
        do_req(2'd3, 32'h18, 32'h7);
        wr_block = 1'b0;
        wait_idle();
        chk(bmem[6] == 32'hC, "R5 locked add result in memory", bmem[6], 32'hC);

        // random streams under a memory that stalls
        rand_ready = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [1:0] op;
            sel = $urandom_range(19);
            op  = (sel < 8) ? 2'd1 : (sel < 16) ? 2'd0 : (sel < 18) ? 2'd2 : 2'd3;
            do_req(op, {26'd0, 3'($urandom_range(5)), 2'b00}, $urandom);
            if ($urandom_range(7) == 0) tick();
        end
        wait_idle();
        chk(erd.size() == 0, "R2 all responses returned", 32'(erd.size()), 32'd0);
        chk(bypass_cnt > 1, "R3 bypass under random traffic", 32'(bypass_cnt), 32'd2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic wait_rsp();
        while (blk) tick();
    endtask

endmodule